// File: doc/BRIEF.md
# Table Jump Instruction Unit

This unit executes a compressed table-jump instruction. Rather than taking its destination from an immediate field, it reads the destination from a table in memory. It adds a scaled index, taken from the instruction, to a base held in the jump-table control register. It fetches one entry with a single-beat data read and redirects the program counter to that entry with bit 0 cleared. Large indices also write the address of the following instruction into the link register x1, which makes the instruction a call. Small indices make a plain jump.

The issuing pipeline presents the instruction, the next-instruction PC, the control-register contents, the XLEN setting and the current data byte order with a one-cycle `start`. The unit captures all of these and holds them until the instruction ends. A small state machine steps through the instruction. `ST_IDLE` goes to `ST_CHECK` on start. `ST_CHECK` goes to `ST_ABORT` when the access gate denies the access or the table mode is not zero; otherwise it goes to `ST_READ_REQ`. `ST_READ_REQ` goes to `ST_WAIT_RSP` when the memory accepts the request. `ST_WAIT_RSP` goes to `ST_COMMIT` on a good response, or to `ST_ABORT` on an error response. `ST_COMMIT` and `ST_ABORT` both return to `ST_IDLE` after one cycle.

Top module: `tbljmp_unit`

## Requirements
- R1: The table index is instruction bits [9:2]. The table base is the control register with its low 6 bits cleared. The read address is base + index*4 truncated to 32 bits (zero-extended) when `xlen64`=0, or base + index*8 when `xlen64`=1. `mem_dword` is 0 for a 4-byte read and 1 for an 8-byte read.
- R2: When `big_end`=0, the entry is taken from the response bytes as they arrive, with byte lane 0 least significant. When `big_end`=1, the 4 bytes (XLEN 32) or 8 bytes (XLEN 64) are reversed before use.
- R3: The new PC is the entry with bit 0 forced to 0. With XLEN 32 the 32-bit entry is sign-extended from bit 31.
- R4: An index of 32 or more asserts `link_we` with `link_data` equal to the captured next PC, in the same cycle as `pc_valid`. An index below 32 never asserts `link_we`.
- R5: A mode field (control register bits [5:0]) other than 0 raises `trap_illegal` and issues no memory request.
- R6: `gate_deny` sampled in `ST_CHECK` aborts the instruction with no memory request. It raises `trap_virtual` when `gate_virt`=1 and `trap_illegal` otherwise. The gate verdict takes priority over the mode check.
- R7: An error response raises `access_fault`, and neither `pc_valid` nor `link_we` is asserted for that instruction.
- R8: `mem_req` stays high with a stable address and size until `mem_ready` is seen.
- R9: A trap flag is a one-cycle pulse in the second cycle after the start cycle. `pc_valid` or `access_fault` is a one-cycle pulse in the cycle after the response.
- R10: `start` is ignored while `busy` is high. The instruction in flight completes with its captured values.
- R11: After reset the unit is idle. `busy`, `mem_req`, `pc_valid`, `link_we` and all trap flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue pulse for one instruction |
| insn | input | 16 | Compressed instruction word |
| next_pc | input | 64 | PC of the following instruction |
| jt_csr | input | 64 | Jump-table register: base in bits [63:6], mode in [5:0] |
| xlen64 | input | 1 | 1 selects XLEN 64, 0 selects XLEN 32 |
| big_end | input | 1 | Current data byte order is big-endian |
| gate_deny | input | 1 | Access gate refuses the read-only check |
| gate_virt | input | 1 | Refusal is a virtual-instruction trap |
| busy | output | 1 | Instruction in flight |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 64 | Table entry address |
| mem_dword | output | 1 | 1 for an 8-byte read, 0 for a 4-byte read |
| mem_ready | input | 1 | Request accepted |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_data | input | 64 | Response bytes, lane 0 in bits [7:0] |
| mem_rsp_err | input | 1 | Response carries an access error |
| pc_valid | output | 1 | New PC pulse |
| pc_target | output | 64 | New PC |
| link_we | output | 1 | Write link register x1 |
| link_data | output | 64 | Value written to x1 |
| trap_illegal | output | 1 | Illegal-instruction trap pulse |
| trap_virtual | output | 1 | Virtual-instruction trap pulse |
| access_fault | output | 1 | Table read error pulse |

## Verification
The bench drives `start` on one falling edge and reads `busy` on the next one, when the unit is in `ST_CHECK`. On the falling edge after that it expects either a trap pulse or `mem_req` with the computed address. Each stall cycle is counted and followed by a check that the request is unchanged. The commit or fault pulse is checked on the first falling edge after the response edge, and `busy` must fall one cycle later. Each scenario task steps through these edges explicitly rather than polling, so a result that arrives one cycle early or late is reported.

// File: rtl/tj_pkg.sv
package tj_pkg;

    localparam int MODE_W   = 6;
    localparam int INDEX_W  = 8;
    localparam int INDEX_LSB = 2;
    localparam int LINK_MIN = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_READ_REQ,
        ST_WAIT_RSP,
        ST_COMMIT,
        ST_ABORT
    } tj_state_e;

    typedef enum logic [1:0] {
        AB_NONE,
        AB_ILLEGAL,
        AB_VIRTUAL,
        AB_FAULT
    } tj_abort_e;

endpackage

// File: rtl/tj_addr_gen.sv
// Index extraction, link decision, mode check and entry address.
module tj_addr_gen
    import tj_pkg::*;
#(
    parameter int XW = 64
) (
    input  logic [15:0]   insn,
    input  logic [XW-1:0] csr,
    input  logic          xlen64,
    output logic          mode_legal,
    output logic          link_req,
    output logic [XW-1:0] entry_addr,
    output logic          dword
);
    localparam int SH32 = 2;
    localparam int SH64 = 3;

    logic [INDEX_W-1:0] index;
    logic [XW-1:0]      base;
    logic [XW-1:0]      sum64;
    logic [31:0]        sum32;

    always_comb begin
        index      = insn[INDEX_LSB +: INDEX_W];
        link_req   = (int'(index) >= LINK_MIN);
        mode_legal = (csr[MODE_W-1:0] == '0);
        base       = {csr[XW-1:MODE_W], {MODE_W{1'b0}}};
        sum64      = base + (XW'(index) << SH64);
        sum32      = base[31:0] + (32'(index) << SH32);
        dword      = xlen64;
        entry_addr = xlen64 ? sum64 : {{(XW-32){1'b0}}, sum32};
    end
endmodule

// File: rtl/tj_entry_fmt.sv
// Byte-order correction, width handling and bit-0 clearing of a table entry.
module tj_entry_fmt #(
    parameter int XW = 64
) (
    input  logic [XW-1:0] raw,
    input  logic          xlen64,
    input  logic          big_end,
    output logic [XW-1:0] target
);
    localparam int NB_D = XW / 8;
    localparam int NB_W = 4;

    logic [XW-1:0] rev_d;
    logic [31:0]   rev_w;
    logic [XW-1:0] ent_d;
    logic [31:0]   ent_w;
    logic [XW-1:0] merged;

    for (genvar g = 0; g < NB_D; g++) begin : g_rev_d
        assign rev_d[8*g +: 8] = raw[8*(NB_D-1-g) +: 8];
    end
    for (genvar g = 0; g < NB_W; g++) begin : g_rev_w
        assign rev_w[8*g +: 8] = raw[8*(NB_W-1-g) +: 8];
    end

    always_comb begin
        ent_d  = big_end ? rev_d : raw;
        ent_w  = big_end ? rev_w : raw[31:0];
        merged = xlen64 ? ent_d : {{(XW-32){ent_w[31]}}, ent_w};
        target = {merged[XW-1:1], 1'b0};
    end
endmodule

// File: rtl/tj_ctrl.sv
// Sequencing state machine for one table-jump instruction.
module tj_ctrl
    import tj_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      gate_deny,
    input  logic      gate_virt,
    input  logic      mode_legal,
    input  logic      mem_ready,
    input  logic      rsp_valid,
    input  logic      rsp_err,
    output tj_state_e state,
    output tj_abort_e cause,
    output logic      cap_en,
    output logic      load_en
);
    tj_state_e state_d;
    tj_abort_e cause_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cause <= AB_NONE;
        end else begin
            state <= state_d;
            cause <= cause_d;
        end
    end

    always_comb begin
        state_d = state;
        cause_d = cause;
        cap_en  = 1'b0;
        load_en = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    cap_en  = 1'b1;
                    cause_d = AB_NONE;
                    state_d = ST_CHECK;
                end
            end
            ST_CHECK: begin
                // gate verdict first, then mode legality
                if (gate_deny) begin
                    cause_d = gate_virt ? AB_VIRTUAL : AB_ILLEGAL;
                    state_d = ST_ABORT;
                end else if (!mode_legal) begin
                    cause_d = AB_ILLEGAL;
                    state_d = ST_ABORT;
                end else begin
                    state_d = ST_READ_REQ;
                end
            end
            ST_READ_REQ: begin
                if (mem_ready) state_d = ST_WAIT_RSP;
            end
            ST_WAIT_RSP: begin
                if (rsp_valid) begin
                    if (rsp_err) begin
                        cause_d = AB_FAULT;
                        state_d = ST_ABORT;
                    end else begin
                        load_en = 1'b1;
                        state_d = ST_COMMIT;
                    end
                end
            end
            ST_COMMIT: state_d = ST_IDLE;
            ST_ABORT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/tbljmp_unit.sv
module tbljmp_unit
    import tj_pkg::*;
#(
    parameter int XW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [15:0]   insn,
    input  logic [XW-1:0] next_pc,
    input  logic [XW-1:0] jt_csr,
    input  logic          xlen64,
    input  logic          big_end,
    input  logic          gate_deny,
    input  logic          gate_virt,
    output logic          busy,
    output logic          mem_req,
    output logic [XW-1:0] mem_addr,
    output logic          mem_dword,
    input  logic          mem_ready,
    input  logic          mem_rsp_valid,
    input  logic [XW-1:0] mem_rsp_data,
    input  logic          mem_rsp_err,
    output logic          pc_valid,
    output logic [XW-1:0] pc_target,
    output logic          link_we,
    output logic [XW-1:0] link_data,
    output logic          trap_illegal,
    output logic          trap_virtual,
    output logic          access_fault
);
    // captured instruction context
    logic [15:0]   insn_q;
    logic [XW-1:0] npc_q;
    logic [XW-1:0] csr_q;
    logic          x64_q;
    logic          be_q;
    logic [XW-1:0] tgt_q;

    tj_state_e st;
    tj_abort_e cause;
    logic      cap_en;
    logic      load_en;
    logic      mode_legal;
    logic      link_req;
    logic [XW-1:0] addr_w;
    logic      dword_w;
    logic [XW-1:0] tgt_w;

    tj_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .gate_deny  (gate_deny),
        .gate_virt  (gate_virt),
        .mode_legal (mode_legal),
        .mem_ready  (mem_ready),
        .rsp_valid  (mem_rsp_valid),
        .rsp_err    (mem_rsp_err),
        .state      (st),
        .cause      (cause),
        .cap_en     (cap_en),
        .load_en    (load_en)
    );

    tj_addr_gen #(.XW(XW)) i_addr (
        .insn       (insn_q),
        .csr        (csr_q),
        .xlen64     (x64_q),
        .mode_legal (mode_legal),
        .link_req   (link_req),
        .entry_addr (addr_w),
        .dword      (dword_w)
    );

    tj_entry_fmt #(.XW(XW)) i_fmt (
        .raw     (mem_rsp_data),
        .xlen64  (x64_q),
        .big_end (be_q),
        .target  (tgt_w)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            insn_q <= '0;
            npc_q  <= '0;
            csr_q  <= '0;
            x64_q  <= 1'b0;
            be_q   <= 1'b0;
            tgt_q  <= '0;
        end else begin
            if (cap_en) begin
                insn_q <= insn;
                npc_q  <= next_pc;
                csr_q  <= jt_csr;
                x64_q  <= xlen64;
                be_q   <= big_end;
            end
            if (load_en) tgt_q <= tgt_w;
        end
    end

    // output decode from state
    always_comb begin
        busy         = (st != ST_IDLE);
        mem_req      = (st == ST_READ_REQ);
        mem_addr     = addr_w;
        mem_dword    = dword_w;
        pc_valid     = (st == ST_COMMIT);
        pc_target    = tgt_q;
        link_we      = (st == ST_COMMIT) && link_req;
        link_data    = npc_q;
        trap_illegal = (st == ST_ABORT) && (cause == AB_ILLEGAL);
        trap_virtual = (st == ST_ABORT) && (cause == AB_VIRTUAL);
        access_fault = (st == ST_ABORT) && (cause == AB_FAULT);
    end
endmodule

// File: rtl/tbljmp_unit_chk.sv
module tbljmp_unit_chk #(
    parameter int XW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_req,
    input logic [XW-1:0] mem_addr,
    input logic          mem_dword,
    input logic          mem_ready,
    input logic          mem_rsp_valid,
    input logic          mem_rsp_err,
    input logic          pc_valid,
    input logic [XW-1:0] pc_target,
    input logic          link_we,
    input logic          trap_illegal,
    input logic          trap_virtual,
    input logic          access_fault
);
    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_dword));

    a_r4_link_with_pc: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> pc_valid);

    a_r7_fault_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_valid, trap_illegal, trap_virtual, access_fault}));

    a_r3_even_target: assert property (@(posedge clk) disable iff (!rst_n)
        pc_valid |-> !pc_target[0]);

    a_r9_commit_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pc_valid) |-> $past(mem_rsp_valid && !mem_rsp_err));

    a_r7_fault_after_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(access_fault) |-> $past(mem_rsp_valid && mem_rsp_err));

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !pc_valid && !link_we);
endmodule

bind tbljmp_unit tbljmp_unit_chk #(.XW(XW)) i_tbljmp_unit_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_dword     (mem_dword),
    .mem_ready     (mem_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_err   (mem_rsp_err),
    .pc_valid      (pc_valid),
    .pc_target     (pc_target),
    .link_we       (link_we),
    .trap_illegal  (trap_illegal),
    .trap_virtual  (trap_virtual),
    .access_fault  (access_fault)
);

// File: tb/test_tbljmp_unit.sv
`timescale 1ns/1ps
module test_tbljmp_unit;
    localparam int XW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [15:0]   insn = '0;
    logic [XW-1:0] next_pc = '0;
    logic [XW-1:0] jt_csr = '0;
    logic          xlen64 = 1'b0;
    logic          big_end = 1'b0;
    logic          gate_deny = 1'b0;
    logic          gate_virt = 1'b0;
    logic          busy, mem_req, mem_dword, pc_valid, link_we;
    logic [XW-1:0] mem_addr, pc_target, link_data;
    logic          mem_ready = 1'b0;
    logic          mem_rsp_valid = 1'b0;
    logic [XW-1:0] mem_rsp_data = '0;
    logic          mem_rsp_err = 1'b0;
    logic          trap_illegal, trap_virtual, access_fault;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tbljmp_unit #(.XW(XW)) i_tbljmp_unit (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] swap_bytes(input logic [63:0] v, input bit dw);
        logic [63:0] r = '0;
        int nb = dw ? 8 : 4;
        for (int i = 0; i < nb; i++) r[8*i +: 8] = v[8*(nb-1-i) +: 8];
        return r;
    endfunction

    // kind: 0 commit, 1 illegal, 2 virtual, 3 fault
    task automatic run_jump(input string tag, input int idx, input bit x64, input bit be,
                            input logic [63:0] csr, input logic [63:0] npc, input logic [63:0] entry,
                            input int stall, input int lat, input bit err, input bit deny,
                            input bit virt, input bit poke);
        int kind;
        logic [63:0] base, exp_addr, exp_tgt, bus;
        base = {csr[63:6], 6'b0};
        exp_addr = x64 ? base + (64'(idx) << 3) : {32'b0, base[31:0] + (32'(idx) << 2)};
        exp_tgt  = x64 ? entry : {{32{entry[31]}}, entry[31:0]};
        exp_tgt[0] = 1'b0;
        bus = be ? swap_bytes(entry, x64) : entry;
        if (deny) kind = virt ? 2 : 1;
        else if (csr[5:0] != 0) kind = 1;
        else kind = err ? 3 : 0;

        @(negedge clk);
        start = 1'b1; insn = 16'h8002 | 16'(idx << 2); next_pc = npc; jt_csr = csr;
        xlen64 = x64; big_end = be; gate_deny = deny; gate_virt = virt;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {tag, " R9 busy in check"}, 64'(busy), 64'd1);
        @(negedge clk);
        if (kind == 1 || kind == 2) begin
            chk(trap_illegal == (kind == 1), {tag, " R5/R6 trap_illegal"}, 64'(trap_illegal), 64'(kind == 1));
            chk(trap_virtual == (kind == 2), {tag, " R6 trap_virtual"}, 64'(trap_virtual), 64'(kind == 2));
            chk(!mem_req && !pc_valid, {tag, " R5 no read"}, 64'(mem_req), 64'd0);
            @(negedge clk);
            chk(!busy && !trap_illegal && !trap_virtual, {tag, " R9 trap one cycle"}, 64'(busy), 64'd0);
            return;
        end
        chk(mem_req == 1'b1, {tag, " R9 request due"}, 64'(mem_req), 64'd1);
        chk(mem_addr == exp_addr, {tag, " R1 address"}, mem_addr, exp_addr);
        chk(mem_dword == x64, {tag, " R1 size"}, 64'(mem_dword), 64'(x64));
        mem_ready = (stall == 0);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk(mem_req && mem_addr == exp_addr, {tag, " R8 request held"}, mem_addr, exp_addr);
            if (s == stall - 1) mem_ready = 1'b1;
        end
        @(negedge clk);
        mem_ready = 1'b0;
        chk(!mem_req, {tag, " R8 request dropped"}, 64'(mem_req), 64'd0);
        if (poke) begin
            start = 1'b1; insn = 16'h8002; next_pc = 64'hDEAD; jt_csr = 64'h3; xlen64 = ~x64;
            @(negedge clk);
            start = 1'b0;
        end
        for (int l = 0; l < lat; l++) @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_data = bus; mem_rsp_err = err;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_err = 1'b0;
        if (kind == 3) begin
            chk(access_fault == 1'b1, {tag, " R7 fault"}, 64'(access_fault), 64'd1);
            chk(!pc_valid && !link_we, {tag, " R7 no commit"}, 64'(pc_valid), 64'd0);
        end else begin
            chk(pc_valid == 1'b1, {tag, " R9 commit due"}, 64'(pc_valid), 64'd1);
            chk(pc_target == exp_tgt, {tag, " R2/R3 target"}, pc_target, exp_tgt);
            chk(link_we == (idx >= 32), {tag, " R4 link enable"}, 64'(link_we), 64'(idx >= 32));
            if (idx >= 32)
                chk(link_data == npc, {tag, " R4 link data"}, link_data, npc);
        end
        @(negedge clk);
        chk(!busy && !pc_valid && !link_we && !access_fault, {tag, " R9 single pulse"}, 64'(busy), 64'd0);
    endtask

    task automatic t_reset();
        chk(!busy && !mem_req && !pc_valid && !link_we, "R11 reset idle", 64'(busy), 64'd0);
        chk(!trap_illegal && !trap_virtual && !access_fault, "R11 reset traps", 64'(trap_illegal), 64'd0);
    endtask

    task automatic t_jump_le32();
        run_jump("jump32le", 5, 1'b0, 1'b0, 64'h0000_0000_8000_0040, 64'h1002, 64'h8000_1235, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_call_be64();
        run_jump("call64be", 200, 1'b1, 1'b1, 64'h0000_0010_0000_0100, 64'h4000_2222,
                 64'h0123_4567_89AB_CDEF, 2, 3, 0, 0, 0, 0);
    endtask

    task automatic t_link_boundary();
        run_jump("idx31", 31, 1'b1, 1'b0, 64'h2000, 64'h500, 64'h7777_0000_0000_1001, 0, 1, 0, 0, 0, 0);
        run_jump("idx32", 32, 1'b0, 1'b1, 64'hFFFF_FFC0, 64'h600, 64'h0000_0000_1234_5679, 1, 0, 0, 0, 0, 0);
    endtask

    task automatic t_bad_mode();
        run_jump("badmode", 40, 1'b1, 1'b0, 64'h3001, 64'h0, 64'h0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_gate_deny();
        run_jump("deny_ill", 10, 1'b1, 1'b0, 64'h3000, 64'h0, 64'h0, 0, 0, 0, 1, 0, 0);
        run_jump("deny_virt", 10, 1'b1, 1'b0, 64'h3002, 64'h0, 64'h0, 0, 0, 0, 1, 1, 0);
    endtask

    task automatic t_mem_err();
        run_jump("memerr", 50, 1'b1, 1'b0, 64'h8000, 64'h900, 64'h4444, 1, 2, 1, 0, 0, 0);
    endtask

    task automatic t_busy_ignore();
        run_jump("poke_R10", 33, 1'b1, 1'b0, 64'h1_0000, 64'hABC0, 64'h5555_6666_7777_8889, 0, 1, 0, 0, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_jump_le32();
        t_call_be64();
        t_link_boundary();
        t_bad_mode();
        t_gate_deny();
        t_mem_err();
        t_busy_ignore();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule